// File: doc/BRIEF.md
# Load Result Alignment and Extension

This unit sits at the end of a load pipeline. It takes the 64-bit doubleword that memory returned for a load and turns it into the value the destination register receives. The low three bits of the physical address say where the wanted bytes sit inside the doubleword. The unit moves those bytes down to bit 0 and then widens the value to 64 bits. A byte, halfword or word is sign-extended or zero-extended, depending on the operation. A single-precision word headed for a floating-point register is NaN-boxed instead.

The block is purely combinational and has no clock or reset. A small decoder turns the operation code and the floating-point flag into a bundle of strobes. A datapath then shifts the data and fills the upper bits as those strobes direct. Accesses that straddle a doubleword boundary, fault reporting and the memory access itself belong to neighbouring logic.

Top module: `load_result_align`

## Requirements
- R1: The result is built from the data shifted right by 8 times `addrLow` bits, so the byte at offset `addrLow` lands in bits 7:0.
- R2: Opcode 3'b000 (signed byte) sign-extends shifted bits 7:0, and opcode 3'b001 (signed halfword) sign-extends shifted bits 15:0, to 64 bits.
- R3: Opcode 3'b100 (unsigned byte), 3'b101 (unsigned halfword) and 3'b110 (unsigned word) zero-extend shifted bits 7:0, 15:0 and 31:0.
- R4: Opcode 3'b010 (word) sign-extends shifted bits 31:0 when `fpDest` is 0. When `fpDest` is 1, it places shifted bits 31:0 under 32 one bits (NaN boxing).
- R5: Opcode 3'b011 (doubleword) returns the shifted data with no extension, for either value of `fpDest`. At offset 0 the result equals `rawData`.
- R6: `fpDest` has no effect on byte, halfword and unsigned opcodes.
- R7: Opcode 3'b111 is undefined and yields an all-zero result for any data, offset and `fpDest`.
- R8: The output depends only on the present inputs and follows an input change without any clock edge. With all inputs at zero the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rawData | input | 64 | Doubleword read from memory |
| addrLow | input | 3 | Byte offset of the load within the doubleword |
| loadOp | input | 3 | Operation: bit 2 selects unsigned, bits 1:0 select the size (0 byte, 1 half, 2 word, 3 double) |
| fpDest | input | 1 | Destination is a floating-point register |
| result | output | 64 | Aligned and extended register value |

## Verification
On every input change, the assertions check the following:
- the strobes are mutually consistent;
- an undefined opcode drives zero;
- a zero-extended result has clear upper bits;
- a sign-extended result repeats its top kept bit upward;
- a boxed word has its upper half all ones.

Whether the right bytes were selected for each offset, and whether the floating-point flag leaves narrow loads untouched, only the bench can show. It does this by comparing every opcode at every offset, with both flag values, against its own model over random and directed data.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;
  localparam int LD_SIZES   = 4;
  localparam int SIZE_W     = $clog2(LD_SIZES);
  localparam int OP_W       = SIZE_W + 1;
  localparam int BOX_SIZE   = 2;

  typedef struct packed {
    logic [LD_SIZES-1:0] sizeOneHot;
    logic                signFill;
    logic                boxFill;
    logic                forceZero;
  } ext_strobe_t;
endpackage

// File: rtl/ldalign_ctrl.sv
module ldalign_ctrl
  import ldalign_pkg::*;
(
  input  logic [OP_W-1:0] loadOp,
  input  logic            fpDest,
  output ext_strobe_t     strobe
);
  localparam logic [SIZE_W-1:0] MAX_SIZE = SIZE_W'(LD_SIZES - 1);
  localparam logic [SIZE_W-1:0] BOX_CODE = SIZE_W'(BOX_SIZE);

  logic [SIZE_W-1:0] sizeCode;
  logic              isUnsigned;
  logic              isUndefined;
  logic              isFull;

  always_comb begin
    sizeCode    = loadOp[SIZE_W-1:0];
    isUnsigned  = loadOp[OP_W-1];
    isFull      = (sizeCode == MAX_SIZE);
    isUndefined = isUnsigned && isFull;

    strobe.forceZero  = isUndefined;
    strobe.sizeOneHot = isUndefined ? '0 : (LD_SIZES'(1) << sizeCode);
    strobe.boxFill    = fpDest && !isUnsigned && (sizeCode == BOX_CODE);
    strobe.signFill   = !isUnsigned && !isFull && !strobe.boxFill;
  end

  always_comb begin
    a_r7_undef_no_size: assert (!strobe.forceZero || strobe.sizeOneHot == '0)
      else $error("undefined opcode still selects a size");
    a_r1_one_size: assert ($onehot0(strobe.sizeOneHot))
      else $error("more than one size selected");
    a_r4_box_excl: assert (!(strobe.boxFill && strobe.signFill))
      else $error("box and sign fill both set");
    a_r6_narrow_no_box: assert (!strobe.boxFill || strobe.sizeOneHot[BOX_SIZE])
      else $error("boxing requested for a non-word size");
  end
endmodule

// File: rtl/ldalign_datapath.sv
module ldalign_datapath
  import ldalign_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [(BYTE_W << (LD_SIZES-1))-1:0]        rawData,
  input  logic [$clog2(1 << (LD_SIZES-1))-1:0]       addrLow,
  input  ext_strobe_t                                strobe,
  output logic [(BYTE_W << (LD_SIZES-1))-1:0]        result
);
  localparam int DATA_W = BYTE_W << (LD_SIZES - 1);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int BOX_W  = BYTE_W << BOX_SIZE;

  logic [DATA_W-1:0]   laneShift [LANES];
  logic [DATA_W-1:0]   sizeMask  [LD_SIZES];
  logic [LD_SIZES-1:0] topBit;
  logic [DATA_W-1:0]   shifted;
  logic [DATA_W-1:0]   keepMask;
  logic                keptMsb;
  logic                fillBit;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneShift[k] = rawData >> (k * BYTE_W);
  end

  assign shifted = laneShift[addrLow];

  for (genvar s = 0; s < LD_SIZES; s++) begin : g_size
    localparam int W = BYTE_W << s;
    if (W < DATA_W) begin : g_part
      assign sizeMask[s] = {{(DATA_W - W){1'b0}}, {W{1'b1}}};
    end else begin : g_full
      assign sizeMask[s] = '1;
    end
    assign topBit[s] = shifted[W-1];
  end

  always_comb begin
    keepMask = '0;
    keptMsb  = 1'b0;
    for (int s = 0; s < LD_SIZES; s++) begin
      if (strobe.sizeOneHot[s]) begin
        keepMask = keepMask | sizeMask[s];
        keptMsb  = keptMsb | topBit[s];
      end
    end
    fillBit = strobe.boxFill | (strobe.signFill & keptMsb);
    if (strobe.forceZero) result = '0;
    else result = (shifted & keepMask) | ({DATA_W{fillBit}} & ~keepMask);
  end

  always_comb begin
    a_r7_zero_out: assert (!strobe.forceZero || result == '0)
      else $error("undefined opcode gave nonzero result");
    a_r3_zero_upper: assert (!(strobe.sizeOneHot[0] && !strobe.signFill) ||
                             result[DATA_W-1:BYTE_W] == '0)
      else $error("unsigned byte has set upper bits");
    a_r2_sign_byte: assert (!(strobe.sizeOneHot[0] && strobe.signFill) ||
                            result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result[BYTE_W-1]}})
      else $error("signed byte not sign-extended");
    a_r4_boxed: assert (!strobe.boxFill || result[DATA_W-1:BOX_W] == '1)
      else $error("boxed word upper half not all ones");
    a_r5_full_pass: assert (!strobe.sizeOneHot[LD_SIZES-1] || result == shifted)
      else $error("doubleword result altered");
  end
endmodule

// File: rtl/load_result_align.sv
module load_result_align
  import ldalign_pkg::*;
(
  input  logic [63:0] rawData,
  input  logic [2:0]  addrLow,
  input  logic [2:0]  loadOp,
  input  logic        fpDest,
  output logic [63:0] result
);
  ext_strobe_t strobe;

  ldalign_ctrl u_ctrl (
    .loadOp (loadOp),
    .fpDest (fpDest),
    .strobe (strobe)
  );

  ldalign_datapath #(.BYTE_W(8)) u_datapath (
    .rawData (rawData),
    .addrLow (addrLow),
    .strobe  (strobe),
    .result  (result)
  );
endmodule

// File: tb/test_load_result_align.sv
module test_load_result_align;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rawData;
  logic [2:0]  addrLow;
  logic [2:0]  loadOp;
  logic        fpDest;
  logic [63:0] result;
  int          totalCount = 0;
  int          failCount  = 0;
  int          cycles     = 0;
  bit          done       = 1'b0;

  load_result_align i_load_result_align (
    .rawData (rawData),
    .addrLow (addrLow),
    .loadOp  (loadOp),
    .fpDest  (fpDest),
    .result  (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(logic [63:0] d, logic [2:0] ofs,
                                        logic [2:0] op, logic fp);
    logic [63:0] sh;
    sh = d >> (ofs * 8);
    case (op)
      3'b000: model = {{56{sh[7]}}, sh[7:0]};
      3'b001: model = {{48{sh[15]}}, sh[15:0]};
      3'b010: model = fp ? {32'hFFFF_FFFF, sh[31:0]} : {{32{sh[31]}}, sh[31:0]};
      3'b011: model = sh;
      3'b100: model = {56'd0, sh[7:0]};
      3'b101: model = {48'd0, sh[15:0]};
      3'b110: model = {32'd0, sh[31:0]};
      default: model = 64'd0;
    endcase
  endfunction

  function automatic string reqOf(logic [2:0] op, logic fp);
    case (op)
      3'b000, 3'b001: reqOf = fp ? "R6" : "R2";
      3'b010:         reqOf = "R4";
      3'b011:         reqOf = "R5";
      3'b111:         reqOf = "R7";
      default:        reqOf = fp ? "R6" : "R3";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    totalCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: op=%0d ofs=%0d fp=%0b got %h expected %h",
               req, loadOp, addrLow, fpDest, got, exp);
    end
  endtask

  task automatic apply(logic [63:0] d, logic [2:0] ofs, logic [2:0] op, logic fp, string req);
    rawData = d; addrLow = ofs; loadOp = op; fpDest = fp;
    #1;
    check(req, result, model(d, ofs, op, fp));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      totalCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rawData = '0; addrLow = '0; loadOp = '0; fpDest = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R8", result, 64'd0);

    // R1: each byte distinct, offset selects lane
    for (int o = 0; o < 8; o++) apply(64'h8877_6655_4433_2211, 3'(o), 3'b100, 1'b0, "R1");
    // R2: negative byte and half
    apply(64'h0000_0000_0000_0080, 3'd0, 3'b000, 1'b0, "R2");
    apply(64'h8000_0000_0000_0000, 3'd6, 3'b001, 1'b0, "R2");
    // R3: all ones zero-extended
    apply('1, 3'd4, 3'b110, 1'b0, "R3");
    apply('1, 3'd7, 3'b101, 1'b0, "R3");
    // R4: word int vs fp
    apply(64'h8000_0000_1234_5678, 3'd4, 3'b010, 1'b0, "R4");
    apply(64'h0000_0000_1234_5678, 3'd0, 3'b010, 1'b1, "R4");
    // R5: doubleword pass through
    apply(64'hDEAD_BEEF_CAFE_F00D, 3'd0, 3'b011, 1'b1, "R5");
    check("R5", result, 64'hDEAD_BEEF_CAFE_F00D);
    // R6: fp flag ignored on narrow ops
    apply(64'h0000_0000_0000_00F0, 3'd0, 3'b000, 1'b1, "R6");
    apply(64'h0000_0000_0000_F000, 3'd0, 3'b101, 1'b1, "R6");
    // R7: undefined opcode
    apply('1, 3'd3, 3'b111, 1'b1, "R7");
    check("R7", result, 64'd0);
    // R8: output follows input without a clock edge
    rawData = 64'h0000_0000_0000_AB00; addrLow = 3'd0; loadOp = 3'b100; fpDest = 1'b0;
    #1;
    addrLow = 3'd1;
    #1;
    check("R8", result, 64'h0000_0000_0000_00AB);

    for (int n = 0; n < 20; n++) begin
      for (int op = 0; op < 8; op++) begin
        for (int o = 0; o < 8; o++) begin
          for (int f = 0; f < 2; f++) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            apply(d, 3'(o), 3'(op), f[0], reqOf(3'(op), f[0]));
          end
        end
      end
    end

    done = 1'b1;
    finishRun();
  end
endmodule